// File: doc/BRIEF.md
# Serial Programming Target Port

This block is the device-side controller of a two-wire serial port that loads and verifies a nonvolatile program memory organised as 14-bit words. A programmer toggles a clock pin and drives or reads a data pin. The block samples both pins in its own faster system clock domain and detects the pin clock's edges there. It decodes 6-bit commands, moves 14-bit words inside 16-clock frames, and keeps an address counter. Its outputs to the memory are an address, a write word, a read strobe and the start/stop strobes of a programming pulse.

The address space is split into a user half (top counter bit clear) and a configuration half (top counter bit set). Loading the configuration word moves the counter to the base of the configuration half. The counter then stays in that half until programming mode is left. The high-voltage enable is modelled as the input `prog_en`. The mode is entered only if both pins are low when that input rises. Dropping it resets all the port's state.

Top module: `sprog_target`

## Requirements
- R1: Programming mode is entered only when `prog_en` rises while the synchronised pin clock and pin data are both low. If either pin is high at that moment, all pin activity is ignored until `prog_en` falls and rises again.
- R2: A command is six pin-clock cycles. Its bits are captured on falling pin-clock edges, least significant bit first. The 6-bit codes are: load config 0x00, load data 0x02, read data 0x04, increment 0x06, begin programming 0x08, end programming 0x0E. Any other code has no effect on the counter, the strobes or the error flag.
- R3: A load frame is 16 pin-clock cycles. Bits captured on falling edges 2 through 15 form the word, least significant bit first. Edges 1 and 16 are the start and stop bits and are discarded. The word appears on `mem_wdata` after the 16th falling edge.
- R4: Load config sets the counter to 2^(ADDR_W-1) (0x2000 by default) as soon as the command is decoded, and is then followed by a load frame.
- R5: Read data pulses `mem_rd` for one cycle with `mem_addr` holding the counter. `mem_rdata` must be valid the following cycle. In the read frame the data pin is enabled from the 2nd rising edge, which drives bit 0. Rising edges 3 to 15 drive bits 1 to 13, and the 16th rising edge releases the pin.
- R6: In the user half, increment counts 0 to 2^(ADDR_W-1)-1 and then wraps to 0.
- R7: In the configuration half, increment wraps from the top address back to the half's base. The top counter bit never clears while the mode stays on.
- R8: Begin programming that follows a completed load frame gives a one-cycle `prog_start` pulse and sets `prog_active`. The load is then used up.
- R9: Begin programming with no unused load sets `seq_err` and gives no `prog_start`. `seq_err` stays set until the mode is left.
- R10: End programming clears `prog_active` and, if a pulse was active, gives a one-cycle `prog_stop`.
- R11: When `prog_en` is low, the next cycle shows a zero counter, a released pin, `seq_err` and `prog_active` clear, and no pending load. A command that completes in the same cycle as the exit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the pin clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_en | input | 1 | Programming high-voltage present |
| pin_clk | input | 1 | Serial clock pin (asynchronous) |
| pin_dat_in | input | 1 | Serial data pin, input side |
| pin_dat_out | output | 1 | Serial data pin, output value |
| pin_dat_oe | output | 1 | Serial data pin output enable |
| mem_addr | output | ADDR_W | Memory address (the counter) |
| mem_wdata | output | DATA_W | Last loaded word |
| mem_rdata | input | DATA_W | Memory read word, valid one cycle after `mem_rd` |
| mem_rd | output | 1 | One-cycle read request |
| prog_start | output | 1 | One-cycle start of a programming pulse |
| prog_stop | output | 1 | One-cycle end of a programming pulse |
| prog_active | output | 1 | Programming pulse in progress |
| seq_err | output | 1 | Sticky flag: begin without a load |

## Verification
The collision that matters is mode exit landing in the same system cycle as the falling pin edge that completes a command. In that case the reset must win, and no strobe or counter change may leak out. The bench loads a word, shifts five bits of a begin-programming command, and then drops the last pin-clock edge. It drops `prog_en` exactly two system edges later, so the synchronised fall is acted on in the same edge as the exit. It then judges four things: that `prog_start` never pulses, that the counter and `seq_err` are zero, and that after re-entry a begin programming reports the sequence error because the load was discarded.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
  localparam int CMD_BITS = 6;

  localparam logic [CMD_BITS-1:0] CMD_LDCFG = 6'h00;
  localparam logic [CMD_BITS-1:0] CMD_LDDAT = 6'h02;
  localparam logic [CMD_BITS-1:0] CMD_RDDAT = 6'h04;
  localparam logic [CMD_BITS-1:0] CMD_INC   = 6'h06;
  localparam logic [CMD_BITS-1:0] CMD_BEGIN = 6'h08;
  localparam logic [CMD_BITS-1:0] CMD_END   = 6'h0E;

  typedef enum logic [1:0] {
    FS_CMD  = 2'd0,
    FS_LOAD = 2'd1,
    FS_READ = 2'd2
  } fstate_e;
endpackage

// File: rtl/sprog_pin_sync.sv
module sprog_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_clk,
  input  logic pin_dat,
  output logic lvl_clk,
  output logic lvl_dat,
  output logic clk_rise,
  output logic clk_fall
);
  localparam int NPINS = 2;

  logic [NPINS-1:0]  pins;
  logic [STAGES-1:0] chain [NPINS];
  logic              clk_prev;

  assign pins = {pin_dat, pin_clk};

  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= '0;
      else     chain[g] <= {chain[g][STAGES-2:0], pins[g]};
    end
  end

  assign lvl_clk = chain[0][STAGES-1];
  assign lvl_dat = chain[1][STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) clk_prev <= 1'b0;
    else     clk_prev <= lvl_clk;
  end

  assign clk_rise = lvl_clk & ~clk_prev;
  assign clk_fall = ~lvl_clk & clk_prev;
endmodule

// File: rtl/sprog_pc.sv
module sprog_pc #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              set_cfg,
  input  logic              inc,
  output logic [ADDR_W-1:0] pc
);
  localparam int LOW_W = ADDR_W - 1;

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst || clr)   pc_q <= '0;
    else if (set_cfg) pc_q <= {1'b1, {LOW_W{1'b0}}};
    else if (inc)     pc_q <= {pc_q[ADDR_W-1], pc_q[LOW_W-1:0] + 1'b1};
  end

  assign pc = pc_q;

  // R7
  cfg_half_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_q[ADDR_W-1] && !clr) |=> pc_q[ADDR_W-1]);

  // R6
  half_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && !set_cfg && (&pc_q[LOW_W-1:0])) |=> (pc_q[LOW_W-1:0] == '0));
endmodule

// File: rtl/sprog_frame.sv
module sprog_frame
  import sprog_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                sclk_rise,
  input  logic                sclk_fall,
  input  logic                sdat,
  input  logic [DATA_W-1:0]   rdata,
  input  logic                rdata_vld,
  output logic                cmd_vld,
  output logic [CMD_BITS-1:0] cmd_code,
  output logic                load_done,
  output logic [DATA_W-1:0]   load_word,
  output logic                dat_oe,
  output logic                dat_out
);
  localparam int FRAME = DATA_W + 2;
  localparam int CNT_W = $clog2(FRAME);
  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_DAT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_FRM = CNT_W'(FRAME - 1);

  fstate_e              state;
  logic [CNT_W-1:0]     cnt;
  logic [CMD_BITS-1:0]  csh;
  logic [CMD_BITS-1:0]  code_next;
  logic [DATA_W-1:0]    wsh;
  logic [DATA_W-1:0]    rsh;
  fstate_e              after_cmd;
  logic                 in_word;

  assign code_next = {sdat, csh[CMD_BITS-1:1]};
  assign in_word   = (cnt != '0) && (cnt <= LAST_DAT);

  always_comb begin
    case (code_next)
      CMD_LDCFG, CMD_LDDAT: after_cmd = FS_LOAD;
      CMD_RDDAT:            after_cmd = FS_READ;
      default:              after_cmd = FS_CMD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state     <= FS_CMD;
      cnt       <= '0;
      csh       <= '0;
      cmd_vld   <= 1'b0;
      cmd_code  <= '0;
      load_done <= 1'b0;
      load_word <= '0;
      wsh       <= '0;
      rsh       <= '0;
      dat_oe    <= 1'b0;
      dat_out   <= 1'b0;
    end else begin
      cmd_vld   <= 1'b0;
      load_done <= 1'b0;
      if (rdata_vld) rsh <= rdata;
      case (state)
        FS_CMD: begin
          if (sclk_fall) begin
            csh <= code_next;
            if (cnt == LAST_CMD) begin
              cnt      <= '0;
              cmd_vld  <= 1'b1;
              cmd_code <= code_next;
              state    <= after_cmd;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        FS_LOAD: begin
          if (sclk_fall) begin
            if (in_word) wsh <= {sdat, wsh[DATA_W-1:1]};
            if (cnt == LAST_FRM) begin
              cnt       <= '0;
              load_done <= 1'b1;
              load_word <= wsh;
              state     <= FS_CMD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        FS_READ: begin
          if (sclk_rise) begin
            if (in_word) begin
              dat_oe  <= 1'b1;
              dat_out <= rsh[0];
              rsh     <= {1'b0, rsh[DATA_W-1:1]};
            end else if (cnt == LAST_FRM) begin
              dat_oe  <= 1'b0;
              dat_out <= 1'b0;
            end
          end
          if (sclk_fall) begin
            if (cnt == LAST_FRM) begin
              cnt   <= '0;
              state <= FS_CMD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= FS_CMD;
      endcase
    end
  end

  // R2
  cmd_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_vld |=> !cmd_vld);

  // R5
  pin_released_outside_read_chk: assert property (@(posedge clk) disable iff (rst)
    (state == FS_CMD) |-> !dat_oe);

  // R3
  load_not_during_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    load_done |-> !cmd_vld);
endmodule

// File: rtl/sprog_target.sv
module sprog_target
  import sprog_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_en,
  input  logic              pin_clk,
  input  logic              pin_dat_in,
  output logic              pin_dat_out,
  output logic              pin_dat_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              prog_start,
  output logic              prog_stop,
  output logic              prog_active,
  output logic              seq_err
);
  logic                lvl_clk, lvl_dat, sclk_rise, sclk_fall;
  logic                en_d, mode_on, kill;
  logic                cmd_vld, load_done, loaded, rd_vld;
  logic [CMD_BITS-1:0] cmd_code;

  sprog_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pin_clk  (pin_clk),
    .pin_dat  (pin_dat_in),
    .lvl_clk  (lvl_clk),
    .lvl_dat  (lvl_dat),
    .clk_rise (sclk_rise),
    .clk_fall (sclk_fall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d    <= 1'b0;
      mode_on <= 1'b0;
    end else begin
      en_d <= prog_en;
      if (!prog_en)   mode_on <= 1'b0;
      else if (!en_d) mode_on <= !lvl_clk && !lvl_dat;
    end
  end

  assign kill = !prog_en || !mode_on;

  sprog_frame #(.DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .clr       (kill),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdat      (lvl_dat),
    .rdata     (mem_rdata),
    .rdata_vld (rd_vld),
    .cmd_vld   (cmd_vld),
    .cmd_code  (cmd_code),
    .load_done (load_done),
    .load_word (mem_wdata),
    .dat_oe    (pin_dat_oe),
    .dat_out   (pin_dat_out)
  );

  sprog_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .clr     (kill),
    .set_cfg (cmd_vld && (cmd_code == CMD_LDCFG)),
    .inc     (cmd_vld && (cmd_code == CMD_INC)),
    .pc      (mem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      mem_rd      <= 1'b0;
      rd_vld      <= 1'b0;
      prog_start  <= 1'b0;
      prog_stop   <= 1'b0;
      prog_active <= 1'b0;
      seq_err     <= 1'b0;
      loaded      <= 1'b0;
    end else begin
      mem_rd     <= 1'b0;
      prog_start <= 1'b0;
      prog_stop  <= 1'b0;
      rd_vld     <= mem_rd;
      if (load_done) loaded <= 1'b1;
      if (cmd_vld) begin
        case (cmd_code)
          CMD_RDDAT: mem_rd <= 1'b1;
          CMD_BEGIN: begin
            if (loaded) begin
              prog_start  <= 1'b1;
              prog_active <= 1'b1;
              loaded      <= 1'b0;
            end else begin
              seq_err <= 1'b1;
            end
          end
          CMD_END: begin
            if (prog_active) prog_stop <= 1'b1;
            prog_active <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // R9
  no_blind_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && (cmd_code == CMD_BEGIN) && !loaded && !kill) |=> (!prog_start && seq_err));

  // R11
  exit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !prog_en |=> (!pin_dat_oe && (mem_addr == '0) && !seq_err && !prog_active));

  // R8
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_start, prog_stop, mem_rd}));

  // R10
  stop_ends_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    prog_stop |-> !prog_active);
endmodule

// File: tb/test_sprog_target.sv
`timescale 1ns/1ps
module test_sprog_target;
  localparam int AW   = 6;
  localparam int DW   = 14;
  localparam int HALF = 1 << (AW - 1);
  localparam int PH   = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          prog_en = 1'b0;
  logic          pin_clk = 1'b0;
  logic          pin_dat_in = 1'b0;
  logic          pin_dat_out, pin_dat_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_rd, prog_start, prog_stop, prog_active, seq_err;

  int n_run = 0;
  int n_fail = 0;
  int start_cnt = 0;
  int stop_cnt = 0;
  int rd_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sprog_target #(.ADDR_W(AW), .DATA_W(DW)) i_sprog_target (
    .clk(clk), .rst(rst), .prog_en(prog_en), .pin_clk(pin_clk),
    .pin_dat_in(pin_dat_in), .pin_dat_out(pin_dat_out), .pin_dat_oe(pin_dat_oe),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .prog_start(prog_start), .prog_stop(prog_stop),
    .prog_active(prog_active), .seq_err(seq_err)
  );

  function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
    logic [DW-1:0] w;
    w = DW'(a);
    return DW'(w * 14'd421 + 14'h0155);
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= model(mem_addr);

  always @(negedge clk) begin
    if (prog_start) start_cnt++;
    if (prog_stop)  stop_cnt++;
    if (mem_rd)     rd_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pin_cycle(input logic b);
    pin_dat_in = b;
    pin_clk = 1'b1;
    repeat (PH) @(negedge clk);
    pin_clk = 1'b0;
    repeat (PH) @(negedge clk);
  endtask

  task automatic gap();
    pin_dat_in = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [5:0] code);
    for (int b = 0; b < 6; b++) pin_cycle(code[b]);
    gap();
  endtask

  task automatic send_word(input logic [DW-1:0] w);
    pin_cycle(1'b0);
    for (int b = 0; b < DW; b++) pin_cycle(w[b]);
    pin_cycle(1'b0);
    gap();
  endtask

  task automatic read_frame(input logic [DW-1:0] exp, input string req);
    int errs = 0;
    logic [DW-1:0] got = '0;
    for (int k = 0; k < DW + 2; k++) begin
      bit exp_oe;
      pin_dat_in = 1'b0;
      pin_clk = 1'b1;
      repeat (PH) @(negedge clk);
      exp_oe = (k >= 1) && (k <= DW);
      if (pin_dat_oe !== exp_oe) errs++;
      if (exp_oe) begin
        got[k-1] = pin_dat_out;
        if (pin_dat_out !== exp[k-1]) errs++;
      end
      pin_clk = 1'b0;
      repeat (PH) @(negedge clk);
    end
    gap();
    check(errs == 0, req, int'(got), int'(exp));
  endtask

  task automatic enter_mode();
    prog_en = 1'b0;
    pin_clk = 1'b0;
    pin_dat_in = 1'b0;
    repeat (6) @(negedge clk);
    prog_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int s0, e0, r0;
    logic [DW-1:0] w;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(mem_addr == 0 && !pin_dat_oe && !seq_err && !prog_active, "R11 reset",
          int'({pin_dat_oe, seq_err, prog_active, mem_addr}), 0);

    // R1: data pin high at entry -> ignored
    pin_dat_in = 1'b1;
    repeat (6) @(negedge clk);
    prog_en = 1'b1;
    repeat (4) @(negedge clk);
    send_cmd(6'h00);
    send_word(14'h0ABC);
    check(mem_addr == 0 && mem_wdata == 0, "R1 entry blocked dat", int'(mem_addr), 0);
    // R1: clock pin high at entry -> ignored
    prog_en = 1'b0;
    pin_clk = 1'b1;
    pin_dat_in = 1'b0;
    repeat (6) @(negedge clk);
    prog_en = 1'b1;
    repeat (4) @(negedge clk);
    pin_clk = 1'b0;
    repeat (4) @(negedge clk);
    send_cmd(6'h06);
    check(mem_addr == 0, "R1 entry blocked clk", int'(mem_addr), 0);

    enter_mode();
    // R2/R6: increment sweep over the user half, including wrap
    for (int i = 1; i <= HALF; i++) begin
      send_cmd(6'h06);
      check(mem_addr == AW'(i % HALF), "R6 user increment", int'(mem_addr), i % HALF);
    end
    send_cmd(6'h06);
    send_cmd(6'h06);
    // R2: every undefined code leaves counter and strobes untouched
    s0 = start_cnt; e0 = stop_cnt; r0 = rd_cnt;
    for (int c = 0; c < 64; c++) begin
      if (c == 0 || c == 2 || c == 4 || c == 6 || c == 8 || c == 14) continue;
      send_cmd(6'(c));
      check(mem_addr == 2 && !seq_err && start_cnt == s0 && stop_cnt == e0 && rd_cnt == r0,
            "R2 undefined code", c, 2);
    end

    // R3: load data with walking ones and patterns
    for (int i = 0; i < DW + 2; i++) begin
      w = (i < DW) ? DW'(1 << i) : ((i == DW) ? 14'h3FFF : 14'h2AAA);
      send_cmd(6'h02);
      send_word(w);
      check(mem_wdata == w, "R3 load word", int'(mem_wdata), int'(w));
    end

    // R5: reads at several user addresses
    for (int i = 0; i < 4; i++) begin
      r0 = rd_cnt;
      send_cmd(6'h04);
      check(rd_cnt == r0 + 1, "R5 read strobe", rd_cnt, r0 + 1);
      read_frame(model(mem_addr), "R5 read frame");
      send_cmd(6'h06);
      send_cmd(6'h06);
      send_cmd(6'h06);
    end

    // R8: load then begin; R10: end
    send_cmd(6'h02);
    send_word(14'h1357);
    s0 = start_cnt;
    send_cmd(6'h08);
    check(start_cnt == s0 + 1 && prog_active, "R8 begin after load", start_cnt, s0 + 1);
    e0 = stop_cnt;
    send_cmd(6'h0E);
    check(stop_cnt == e0 + 1 && !prog_active, "R10 end programming", stop_cnt, e0 + 1);

    // R9: begin without a fresh load
    s0 = start_cnt;
    send_cmd(6'h08);
    check(start_cnt == s0 && seq_err && !prog_active, "R9 blind begin", start_cnt, s0);
    send_cmd(6'h02);
    send_word(14'h0001);
    send_cmd(6'h08);
    check(start_cnt == s0 + 1 && seq_err, "R9 error sticky", int'(seq_err), 1);
    send_cmd(6'h0E);

    // R4: load config
    send_cmd(6'h00);
    check(mem_addr == AW'(HALF), "R4 config base", int'(mem_addr), HALF);
    send_word(14'h1234);
    check(mem_wdata == 14'h1234, "R4 config word", int'(mem_wdata), 'h1234);
    // R7: configuration half sweep and wrap
    for (int i = 1; i <= HALF; i++) begin
      send_cmd(6'h06);
      check(mem_addr == AW'(HALF + (i % HALF)), "R7 config increment", int'(mem_addr),
            HALF + (i % HALF));
    end
    send_cmd(6'h04);
    read_frame(model(mem_addr), "R5 config read");

    // R11: exit collides with the completing begin command
    send_cmd(6'h02);
    send_word(14'h0F0F);
    s0 = start_cnt;
    for (int b = 0; b < 5; b++) pin_cycle(b == 3);
    pin_dat_in = 1'b0;
    pin_clk = 1'b1;
    repeat (PH) @(negedge clk);
    pin_clk = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    prog_en = 1'b0;
    repeat (4) @(negedge clk);
    check(start_cnt == s0, "R11 collision no start", start_cnt, s0);
    check(mem_addr == 0 && !seq_err && !prog_active && !pin_dat_oe, "R11 exit cleared",
          int'({seq_err, prog_active, mem_addr}), 0);
    enter_mode();
    check(mem_addr == 0, "R11 re-entry user half", int'(mem_addr), 0);
    send_cmd(6'h08);
    check(seq_err && start_cnt == s0, "R11 load discarded", int'(seq_err), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule